// File: doc/BRIEF.md
# Video output line timing generator

This block produces the horizontal timing of a scan-rate-converted video output. A line counter driven by the pixel clock marks each line start. From that count the block decodes a fixed-width line sync pulse, a reference window that frames the active region, and a pixel-request strobe that runs ahead of the data by the programmed pipeline delay. It also muxes the luma and chroma output lanes between incoming samples and a programmable border colour.

All positions are set in coarse units. The sync delay counts in steps of 4 clocks, the border width in steps of 4 clocks and the active length in steps of 16 pixels. A fine pipeline delay is added to these positions, and a 2-bit crop code trims the same amount from both ends of the active run. The block either runs free at a programmed period or restarts on an external lock strobe. The configuration is captured only at a line start, so a register write never tears a line.

Top module: `vout_line_timer`

## Requirements
- R1: `hsync_o` is high for the first SYNC_CLKS (default 64) clocks of each line, at counter positions 0 to SYNC_CLKS-1, and low for the rest of the line.
- R2: In free-running mode (`cfg_freerun_i`=1), lines start every 2×`cfg_half_len_i` clocks, and `lock_i` has no effect.
- R3: `href_o` rises at position WS = (`cfg_sync_dly_i`+1)×4 + `cfg_pipe_dly_i` and stays high for N + 8×`cfg_border_i` clocks.
- R4: Inside the window, the first 4×`cfg_border_i` clocks carry border. Sample data follows from position DS = WS + 4×`cfg_border_i` for N clocks, and the window then ends with 4×`cfg_border_i` border clocks.
- R5: The data count is N = 16×`cfg_act_len_i` − 16×`cfg_crop_i`, that is, 16×act minus 2k with k = 8×crop (crop 0..3 gives k = 0, 8, 16, 24). N is clamped to 0 when the result would be negative.
- R6: `req_o` is high exactly `cfg_pipe_dly_i` clocks before each data clock, at positions DS−pd up to DS−pd+N−1.
- R7: On every non-data clock, inside or outside the window, `y_o` = {`cfg_y_nib_i`, 4'h0}. The lower nibble of every border value is zero.
- R8: On non-data clocks, `uv_o` gives {`cfg_u_nib_i`,4'h0} when (position − WS) is even and {`cfg_v_nib_i`,4'h0} when it is odd.
- R9: On data clocks, `y_o` = `y_i` and `uv_o` = `uv_i`.
- R10: In locked mode (`cfg_freerun_i`=0), a `lock_i` high at a clock edge sets the position to 0 on that edge. Without a strobe the count stops at its maximum, and no new sync pulse appears.
- R11: Every `cfg_*` input is sampled only at a line start (and in the first cycle after reset). A change in the middle of a line takes effect from the next line.
- R12: While `rst_n` is low, `hsync_o`, `href_o` and `req_o` are 0, and `y_o` and `uv_o` are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Line restart strobe (locked mode) |
| cfg_freerun_i | input | 1 | 1: free-running, 0: locked |
| cfg_half_len_i | input | 10 | Half the line period in clocks |
| cfg_sync_dly_i | input | 4 | Window delay in 4-clock units (minus one) |
| cfg_pipe_dly_i | input | 4 | Fine pipeline delay in clocks |
| cfg_border_i | input | 4 | Border width per side in 4-clock units |
| cfg_act_len_i | input | 6 | Active length in 16-pixel units |
| cfg_crop_i | input | 2 | Symmetric crop code |
| cfg_y_nib_i | input | 4 | Luma border upper nibble |
| cfg_u_nib_i | input | 4 | U border upper nibble |
| cfg_v_nib_i | input | 4 | V border upper nibble |
| y_i | input | 8 | Incoming luma sample |
| uv_i | input | 8 | Incoming multiplexed chroma sample |
| hsync_o | output | 1 | Line sync pulse |
| href_o | output | 1 | Reference window |
| y_o | output | 8 | Output luma |
| uv_o | output | 8 | Output chroma |
| req_o | output | 1 | Pixel request strobe |

## Verification
The main function is tried with five line setups. These include zero delays and zero border, maximal pipeline delay, every crop code, a full 720-pixel line at an 864-clock period, and a crop that empties the data run. Together they separate errors in the window origin from errors in the border width and in the data count, since each setup moves only some of these positions. The luma and chroma inputs carry a ramp that differs from clock to clock, so a data run that is shifted by even one clock, or a U/V border phase that is swapped, shows up at once. Directed runs then cover the lock strobe in each mode, a count that stops without a strobe, and a register write in the middle of a line.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
  parameter int LEN_W = 10;
  parameter int SD_W  = 4;
  parameter int PD_W  = 4;
  parameter int BC_W  = 4;
  parameter int ACT_W = 6;
  parameter int NIB_W = 4;
  parameter int PIX_W = 8;
  parameter int CNT_W = LEN_W + 2;

  typedef logic [CNT_W-1:0] pos_t;

  typedef struct packed {
    logic             freerun;
    logic [LEN_W-1:0] half_len;
    logic [SD_W-1:0]  sync_dly;
    logic [PD_W-1:0]  pipe_dly;
    logic [BC_W-1:0]  border;
    logic [ACT_W-1:0] act_len;
    logic [1:0]       crop;
    logic [NIB_W-1:0] y_nib;
    logic [NIB_W-1:0] u_nib;
    logic [NIB_W-1:0] v_nib;
  } line_cfg_t;

  // line period in clocks: twice the half-length field
  function automatic pos_t line_period(line_cfg_t c);
    return pos_t'({c.half_len, 1'b0});
  endfunction

  // window origin: coarse 4-clock delay plus fine pipeline delay
  function automatic pos_t win_start(line_cfg_t c);
    pos_t s;
    s = pos_t'(c.sync_dly) + pos_t'(1);
    return (s << 2) + pos_t'(c.pipe_dly);
  endfunction

  function automatic pos_t border_len(line_cfg_t c);
    return pos_t'(c.border) << 2;
  endfunction

  // active sample count after symmetric crop, clamped at zero
  function automatic pos_t data_count(line_cfg_t c);
    pos_t full;
    pos_t trim;
    full = pos_t'(c.act_len) << 4;
    trim = pos_t'(c.crop) << 4;
    return (full > trim) ? full - trim : '0;
  endfunction
endpackage

// File: rtl/vlt_line_counter.sv
module vlt_line_counter
  import vlt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic freerun_i,
  input  pos_t period_i,
  output pos_t cnt_o,
  output logic started_o,
  output logic load_o
);
  pos_t cnt_q;
  logic started_q;
  logic wrap;

  assign wrap   = (cnt_q == period_i - pos_t'(1));
  assign load_o = !started_q || (freerun_i ? wrap : lock_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (load_o)
        cnt_q <= '0;
      else if (cnt_q != '1)
        cnt_q <= cnt_q + pos_t'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign started_o = started_q;
endmodule

// File: rtl/vlt_cfg_shadow.sv
module vlt_cfg_shadow
  import vlt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  line_cfg_t live_i,
  output line_cfg_t held_o
);
  line_cfg_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      held_q <= '0;
    else if (load_i)
      held_q <= live_i;
  end

  assign held_o = held_q;
endmodule

// File: rtl/vlt_region_decode.sv
module vlt_region_decode
  import vlt_pkg::*;
#(
  parameter int SYNC_CLKS = 64
)(
  input  logic            started_i,
  input  pos_t            cnt_i,
  input  pos_t            win_start_i,
  input  pos_t            data_start_i,
  input  pos_t            data_end_i,
  input  pos_t            win_end_i,
  input  logic [PD_W-1:0] pipe_dly_i,
  output logic            sync_o,
  output logic            win_o,
  output logic            data_o,
  output logic            req_o,
  output logic            phase_o
);
  localparam pos_t SYNC_END = pos_t'(SYNC_CLKS);

  logic [CNT_W:0] ahead;
  pos_t           off;

  assign ahead = {1'b0, cnt_i} + {{(CNT_W+1-PD_W){1'b0}}, pipe_dly_i};
  assign off   = cnt_i - win_start_i;

  assign sync_o  = started_i && (cnt_i < SYNC_END);
  assign win_o   = started_i && (cnt_i >= win_start_i) && (cnt_i < win_end_i);
  assign data_o  = started_i && (cnt_i >= data_start_i) && (cnt_i < data_end_i);
  assign req_o   = started_i && (ahead >= {1'b0, data_start_i})
                             && (ahead < {1'b0, data_end_i});
  assign phase_o = off[0];
endmodule

// File: rtl/vout_line_timer.sv
module vout_line_timer
  import vlt_pkg::*;
#(
  parameter int SYNC_CLKS = 64
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             cfg_freerun_i,
  input  logic [LEN_W-1:0] cfg_half_len_i,
  input  logic [SD_W-1:0]  cfg_sync_dly_i,
  input  logic [PD_W-1:0]  cfg_pipe_dly_i,
  input  logic [BC_W-1:0]  cfg_border_i,
  input  logic [ACT_W-1:0] cfg_act_len_i,
  input  logic [1:0]       cfg_crop_i,
  input  logic [NIB_W-1:0] cfg_y_nib_i,
  input  logic [NIB_W-1:0] cfg_u_nib_i,
  input  logic [NIB_W-1:0] cfg_v_nib_i,
  input  logic [PIX_W-1:0] y_i,
  input  logic [PIX_W-1:0] uv_i,
  output logic             hsync_o,
  output logic             href_o,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] uv_o,
  output logic             req_o
);
  localparam int LOW_W = PIX_W - NIB_W;

  line_cfg_t live_cfg;
  line_cfg_t cfg_q;
  pos_t      cnt;
  pos_t      period;
  pos_t      ws, ds, de, we;
  logic      started;
  logic      load_evt;
  logic      in_data;
  logic      uv_phase;

  assign live_cfg = '{freerun:  cfg_freerun_i,  half_len: cfg_half_len_i,
                      sync_dly: cfg_sync_dly_i, pipe_dly: cfg_pipe_dly_i,
                      border:   cfg_border_i,   act_len:  cfg_act_len_i,
                      crop:     cfg_crop_i,     y_nib:    cfg_y_nib_i,
                      u_nib:    cfg_u_nib_i,    v_nib:    cfg_v_nib_i};

  // positions derived from the captured configuration
  assign period = line_period(cfg_q);
  assign ws     = win_start(cfg_q);
  assign ds     = ws + border_len(cfg_q);
  assign de     = ds + data_count(cfg_q);
  assign we     = de + border_len(cfg_q);

  vlt_line_counter cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_i    (lock_i),
    .freerun_i (cfg_q.freerun),
    .period_i  (period),
    .cnt_o     (cnt),
    .started_o (started),
    .load_o    (load_evt)
  );

  vlt_cfg_shadow shadow_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_evt),
    .live_i (live_cfg),
    .held_o (cfg_q)
  );

  vlt_region_decode #(.SYNC_CLKS(SYNC_CLKS)) decode_i (
    .started_i    (started),
    .cnt_i        (cnt),
    .win_start_i  (ws),
    .data_start_i (ds),
    .data_end_i   (de),
    .win_end_i    (we),
    .pipe_dly_i   (cfg_q.pipe_dly),
    .sync_o       (hsync_o),
    .win_o        (href_o),
    .data_o       (in_data),
    .req_o        (req_o),
    .phase_o      (uv_phase)
  );

  // output lanes: samples during the data run, border colour elsewhere
  logic [NIB_W-1:0] uv_nib;
  assign uv_nib = uv_phase ? cfg_q.v_nib : cfg_q.u_nib;
  assign y_o    = in_data ? y_i  : {cfg_q.y_nib, {LOW_W{1'b0}}};
  assign uv_o   = in_data ? uv_i : {uv_nib,      {LOW_W{1'b0}}};
endmodule

// File: rtl/vlt_checker.sv
module vlt_checker
  import vlt_pkg::*;
#(
  parameter int SYNC_CLKS = 64
)(
  input logic             clk,
  input logic             rst_n,
  input logic             lock_i,
  input logic             hsync_o,
  input logic             href_o,
  input logic [PIX_W-1:0] y_i,
  input logic [PIX_W-1:0] y_o,
  input logic [PIX_W-1:0] uv_o,
  input pos_t             cnt,
  input pos_t             period,
  input logic             started,
  input logic             load_evt,
  input line_cfg_t        cfg_q,
  input logic             in_data,
  input logic             uv_phase
);
  localparam pos_t SYNC_END = pos_t'(SYNC_CLKS);

  assert_sync_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cnt == '0) |-> hsync_o);

  assert_sync_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_o) |-> (cnt == SYNC_END));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && cfg_q.freerun && cnt == period - pos_t'(1)) |=> (cnt == '0));

  assert_data_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> href_o);

  assert_border_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |-> (y_o[3:0] == 4'h0 && uv_o[3:0] == 4'h0));

  assert_border_v_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_data && uv_phase) |-> (uv_o[7:4] == cfg_q.v_nib));

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (y_o == y_i));

  assert_lock_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !cfg_q.freerun && lock_i) |=> (cnt == '0));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(cfg_q));
endmodule

bind vout_line_timer vlt_checker #(.SYNC_CLKS(SYNC_CLKS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .lock_i   (lock_i),
  .hsync_o  (hsync_o),
  .href_o   (href_o),
  .y_i      (y_i),
  .y_o      (y_o),
  .uv_o     (uv_o),
  .cnt      (cnt),
  .period   (period),
  .started  (started),
  .load_evt (load_evt),
  .cfg_q    (cfg_q),
  .in_data  (in_data),
  .uv_phase (uv_phase)
);

// File: tb/vout_line_timer_tb_top.sv
module vout_line_timer_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, lock_i = 1'b0, fr = 1'b1;
  logic [9:0] hl = '0;
  logic [3:0] sd = '0, pd = '0, bc = '0, yn = '0, un = '0, vn = '0;
  logic [5:0] al = '0;
  logic [1:0] cr = '0;
  logic [7:0] y_i = '0, uv_i = '0;
  logic       hsync_o, href_o, req_o;
  logic [7:0] y_o, uv_o;

  vout_line_timer dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_freerun_i(fr),
    .cfg_half_len_i(hl), .cfg_sync_dly_i(sd), .cfg_pipe_dly_i(pd),
    .cfg_border_i(bc), .cfg_act_len_i(al), .cfg_crop_i(cr),
    .cfg_y_nib_i(yn), .cfg_u_nib_i(un), .cfg_v_nib_i(vn),
    .y_i(y_i), .uv_i(uv_i), .hsync_o(hsync_o), .href_o(href_o),
    .y_o(y_o), .uv_o(uv_o), .req_o(req_o));

  int errs = 0, checks = 0, t = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  // {half_len, sync_dly, pipe_dly, border, act_len, crop, ynib, unib, vnib,
  //  hand-computed window start, hand-computed data count}
  localparam int NV = 5;
  localparam logic [61:0] VEC [NV] = '{
    {10'd100, 4'd2, 4'd3,  4'd1, 6'd2,  2'd0, 4'hA, 4'h3, 4'hC, 10'd15, 10'd32},
    {10'd150, 4'd0, 4'd0,  4'd0, 6'd3,  2'd1, 4'h5, 4'h6, 4'h9, 10'd4,  10'd32},
    {10'd120, 4'd5, 4'd7,  4'd3, 6'd4,  2'd2, 4'hF, 4'h1, 4'h2, 10'd31, 10'd32},
    {10'd70,  4'd1, 4'd15, 4'd2, 6'd1,  2'd3, 4'h7, 4'h8, 4'hE, 10'd23, 10'd0},
    {10'd432, 4'd3, 4'd2,  4'd2, 6'd45, 2'd0, 4'h1, 4'hD, 4'hB, 10'd18, 10'd720}
  };

  task automatic adv();
    @(posedge clk);
    t++;
  endtask

  task automatic restart();
    rst_n = 1'b0;
    lock_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    t = 0;
  endtask

  task automatic wait_to(int target);
    while (t < target) adv();
    @(negedge clk);
    #1;
  endtask

  initial begin
    // ---------- reset state, R12 ----------
    fr = 1; hl = 10'd100; sd = 4'd2; pd = 4'd3; bc = 4'd1; al = 6'd2;
    yn = 4'hA; un = 4'h3; vn = 4'hC; y_i = 8'h77; uv_i = 8'h99;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hsync_o == 0 && href_o == 0 && req_o == 0, "R12 sync/window/req in reset",
          {hsync_o, href_o, req_o}, 0);
    check(y_o == 8'h00 && uv_o == 8'h00, "R12 lanes in reset", {y_o, uv_o}, 0);

    // ---------- vector table: R1 R3 R4 R5 R6 R7 R8 R9 ----------
    for (int v = 0; v < NV; v++) begin
      int per, ews, en, bw, nhs, nhr, nrq, ny, nuv;
      int ahs, ehs, ahr, ehr, arq, erq, ay, ey, auv, euv;
      per = 2 * int'(VEC[v][61:52]);
      ews = int'(VEC[v][19:10]);
      en  = int'(VEC[v][9:0]);
      bw  = 4 * int'(VEC[v][43:40]);
      hl = VEC[v][61:52]; sd = VEC[v][51:48]; pd = VEC[v][47:44];
      bc = VEC[v][43:40]; al = VEC[v][39:34]; cr = VEC[v][33:32];
      yn = VEC[v][31:28]; un = VEC[v][27:24]; vn = VEC[v][23:20];
      fr = 1'b1;
      nhs = 0; nhr = 0; nrq = 0; ny = 0; nuv = 0;
      ahs = 0; ehs = 0; ahr = 0; ehr = 0; arq = 0; erq = 0;
      ay = 0; ey = 0; auv = 0; euv = 0;
      restart();
      for (int c = 0; c <= per; c++) begin
        int p, xy, xuv, lo;
        bit xhs, xhr, xrq, dat;
        @(negedge clk);
        y_i  = 8'(c * 3 + 1);
        uv_i = 8'(c * 5 + 7);
        #1;
        p   = c % per;
        lo  = ews + bw;
        xhs = (p < 64);
        xhr = (p >= ews) && (p < ews + 2 * bw + en);
        dat = (p >= lo) && (p < lo + en);
        xrq = (p + int'(pd) >= lo) && (p + int'(pd) < lo + en);
        xy  = dat ? int'(y_i) : int'(yn) * 16;
        if (dat) xuv = int'(uv_i);
        else xuv = (((p & 1) ^ (ews & 1)) != 0) ? int'(vn) * 16 : int'(un) * 16;
        if (hsync_o != xhs) begin if (nhs == 0) begin ahs = hsync_o; ehs = xhs; end nhs++; end
        if (href_o != xhr)  begin if (nhr == 0) begin ahr = href_o;  ehr = xhr; end nhr++; end
        if (req_o != xrq)   begin if (nrq == 0) begin arq = req_o;   erq = xrq; end nrq++; end
        if (int'(y_o) != xy)   begin if (ny == 0)  begin ay = y_o;   ey = xy;   end ny++;  end
        if (int'(uv_o) != xuv) begin if (nuv == 0) begin auv = uv_o; euv = xuv; end nuv++; end
        adv();
      end
      check(nhs == 0, $sformatf("R1 R2 sync pulse vec%0d", v), ahs, ehs);
      check(nhr == 0, $sformatf("R3 R5 window vec%0d", v), ahr, ehr);
      check(nrq == 0, $sformatf("R6 request vec%0d", v), arq, erq);
      check(ny == 0,  $sformatf("R4 R7 R9 luma vec%0d", v), ay, ey);
      check(nuv == 0, $sformatf("R8 R9 chroma vec%0d", v), auv, euv);
    end

    // ---------- locked mode, R10 ----------
    fr = 1'b0; hl = 10'd100; sd = 4'd2; pd = 4'd3; bc = 4'd1; al = 6'd2; cr = 2'd0;
    restart();
    wait_to(200);
    check(hsync_o == 0, "R10 no wrap at period when locked", hsync_o, 0);
    wait_to(250);
    check(hsync_o == 0 && href_o == 0, "R10 idle without strobe", {hsync_o, href_o}, 0);
    lock_i = 1'b1;
    adv();
    t = 0;
    #1 lock_i = 1'b0;
    wait_to(0);
    check(hsync_o == 1, "R10 strobe restarts line", hsync_o, 1);
    wait_to(14);
    check(href_o == 0, "R10 window not yet open after restart", href_o, 0);
    wait_to(15);
    check(href_o == 1, "R10 window opens at WS after restart", href_o, 1);

    // ---------- free-running ignores strobe, R2 ----------
    fr = 1'b1;
    restart();
    wait_to(100);
    lock_i = 1'b1;
    adv();
    #1 lock_i = 1'b0;
    wait_to(101);
    check(hsync_o == 0, "R2 strobe ignored in free-run", hsync_o, 0);
    wait_to(199);
    check(hsync_o == 0, "R2 last clock of line", hsync_o, 0);
    wait_to(200);
    check(hsync_o == 1, "R2 next line at 2*half_len", hsync_o, 1);

    // ---------- mid-line register change, R11 ----------
    yn = 4'hA;
    restart();
    wait_to(5);
    sd = 4'd0;
    yn = 4'h6;
    wait_to(7);
    check(href_o == 0, "R11 old window origin kept", href_o, 0);
    check(y_o == 8'hA0, "R11 old border kept", y_o, 8'hA0);
    wait_to(15);
    check(href_o == 1, "R11 old window opens at 15", href_o, 1);
    wait_to(200);
    check(y_o == 8'h60, "R11 new border at next line", y_o, 8'h60);
    wait_to(207);
    check(href_o == 1, "R11 new window origin next line", href_o, 1);

    done = 1;
    report();
  end
endmodule